// File: doc/BRIEF.md
# Hierarchical Page-Table Walker

This block turns a 64-bit virtual address into a physical address by walking a radix tree of 64-bit translation entries held in memory. A caller presents the address, the kind of access (data read, data write or instruction fetch), the frame number of the root table, a depth select (four or five levels) and a no-execute enable. The walker reads one entry at a time through a plain request/response memory port, follows pointer entries downward, and stops on a leaf. It returns either a physical address with a page-size code or a fault code together with the level of the entry that caused it.

Before any memory traffic the upper address bits are checked for sign-extended form, so a malformed address costs no memory read. Large pages end the walk early at two levels: a 1 GB page at level 3 and a 2 MB page at level 2. Level numbering counts down from the root: 5 (only in five-level mode), 4, 3, 2 and 1. Access codes are 0 read, 1 write, 2 fetch. Fault codes are 0 none, 1 non-canonical, 2 not present, 3 write protect, 4 no execute. Size codes are 0 for 4 KB, 1 for 2 MB, 2 for 1 GB.

Top module: `ptw_top`

## Requirements
- R1: In four-level mode an address whose bits 63:47 are not all equal is answered with fault 1 and level 0 in the cycle after acceptance, and no memory read is made.
- R2: In five-level mode the sign check covers bits 63:56 instead; addresses that differ only in bits 55:48 are canonical there, and a mismatch gives fault 1 with no memory read.
- R3: The first read goes to the root frame (root_frame shifted left by 12) plus 8 times the top-level index, the index of level L being address bits 12+9(L-1)+8 down to 12+9(L-1); the top level is 5 in five-level mode and 4 otherwise.
- R4: Each following read goes to entry bits 51:12 shifted left by 12 plus 8 times the next level's index; only one read is outstanding, and the next read is issued only after the previous response.
- R5: A present entry at level 3 with bit 7 set ends the walk with size code 2 and physical address {entry[51:30], va[29:0]}.
- R6: A present entry at level 2 with bit 7 set ends the walk with size code 1 and physical address {entry[51:21], va[20:0]}.
- R7: A present level 1 entry ends the walk with size code 0 and address {entry[51:12], va[11:0]}; bit 7 is ignored at levels 5, 4 and 1, and entry bits 62:52 never reach an address.
- R8: An entry with bit 0 clear ends the walk with fault 2 and the level of that entry.
- R9: A write (access 1) through an entry with bit 1 clear ends the walk with fault 3 and the level of that entry; reads and fetches ignore bit 1.
- R10: A fetch (access 2) with no-execute enable set through an entry with bit 63 set ends the walk with fault 4 and that level; bit 63 has no effect otherwise.
- R11: Entries are checked in walk order and the first faulting entry wins; within one entry a clear bit 0 takes precedence over the write and execute checks.
- R12: rsp_valid is a single-cycle pulse per accepted request; req_ready is high only while idle, and a request presented while busy is ignored.
- R13: After reset req_ready is high and rsp_valid and mem_rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 64 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| five_lvl_en | input | 1 | Selects five-level walk when high |
| nx_en | input | 1 | Enables the no-execute check |
| root_frame | input | 40 | Frame number of the root table (4 KB aligned base) |
| req_ready | output | 1 | High when idle and able to accept a request |
| mem_rd_valid | output | 1 | Entry read request, one cycle |
| mem_rd_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 52 | Translated physical address (0 on fault) |
| rsp_size | output | 2 | Page size code: 0 4 KB, 1 2 MB, 2 1 GB |
| rsp_fault | output | 3 | Fault code, 0 when translation succeeded |
| rsp_level | output | 3 | Level of the leaf or faulting entry, 0 for a sign fault |

## Verification
The hardest case to reach from the ports is a fault at a middle level that coincides with other marked entries above or below it, since the walk must stop at exactly the right entry and issue exactly the right number of reads. The bench memory model builds every entry from the level decoded out of the requested address, with separate knobs that clear the present bit, clear the writable bit or set the no-execute bit at any chosen level, and sweeps each knob across every level, both walk depths and all three access kinds. It also pokes a second request into the middle of a walk and varies response latency per read to expose any early reissue.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 9;
  localparam int MAX_LVL   = 5;
  localparam int ENT_SHIFT = 3;
  localparam int PRES_BIT  = 0;
  localparam int WR_BIT    = 1;
  localparam int PS_BIT    = 7;
  localparam int NX_BIT    = 63;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_NONCANON = 3'd1,
    FLT_NOTPRES  = 3'd2,
    FLT_WRPROT   = 3'd3,
    FLT_NOEXEC   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pgsz_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon
  import ptw_pkg::*;
#(
  parameter int VA_W = 64,
  localparam int TOP4 = OFF_W + 4 * IDX_W - 1,
  localparam int TOP5 = OFF_W + 5 * IDX_W - 1,
  localparam int HI_W = VA_W - TOP4
) (
  input  logic [HI_W-1:0] va_hi,
  input  logic            five_en,
  output logic            ok
);
  logic ok4, ok5;

  always_comb begin
    ok4 = (&va_hi) | ~(|va_hi);
    ok5 = (&va_hi[HI_W-1:TOP5-TOP4]) | ~(|va_hi[HI_W-1:TOP5-TOP4]);
    ok  = five_en ? ok5 : ok4;
  end
endmodule

// File: rtl/ptw_idx.sv
module ptw_idx
  import ptw_pkg::*;
#(
  parameter int LEVELS = MAX_LVL
) (
  input  logic [LEVELS*IDX_W-1:0] vfld,
  input  logic [2:0]              lvl,
  output logic [IDX_W-1:0]        idx
);
  logic [IDX_W-1:0] fld [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = vfld[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == 3'(i + 1)) idx = fld[i];
    end
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int PA_W = 52,
  localparam int FR_W  = PA_W - OFF_W,
  localparam int VOF_W = OFF_W + 2 * IDX_W
) (
  input  logic [FR_W-1:0]  frame,
  input  logic [VOF_W-1:0] voff,
  input  logic [2:0]       lvl,
  output logic [PA_W-1:0]  paddr,
  output pgsz_e            size
);
  always_comb begin
    unique case (lvl)
      3'd3: begin
        paddr = {frame[FR_W-1:2*IDX_W], voff};
        size  = PG_1G;
      end
      3'd2: begin
        paddr = {frame[FR_W-1:IDX_W], voff[OFF_W+IDX_W-1:0]};
        size  = PG_2M;
      end
      default: begin
        paddr = {frame, voff[OFF_W-1:0]};
        size  = PG_4K;
      end
    endcase
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PA_W  = 52,
  parameter int ENT_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_access,
  input  logic                  five_lvl_en,
  input  logic                  nx_en,
  input  logic [PA_W-OFF_W-1:0] root_frame,
  output logic                  req_ready,
  output logic                  mem_rd_valid,
  output logic [PA_W-1:0]       mem_rd_addr,
  input  logic                  mem_rsp_valid,
  input  logic [ENT_W-1:0]      mem_rsp_data,
  output logic                  rsp_valid,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_size,
  output logic [2:0]            rsp_fault,
  output logic [2:0]            rsp_level
);
  localparam int FR_W  = PA_W - OFF_W;
  localparam int VQ_W  = OFF_W + MAX_LVL * IDX_W;
  localparam int VOF_W = OFF_W + 2 * IDX_W;
  localparam int TOP4  = OFF_W + 4 * IDX_W - 1;

  st_e              state_q, st_d;
  logic [2:0]       lvl_q, lvl_d;
  logic [VQ_W-1:0]  va_q;
  acc_e             acc_q;
  logic             nxe_q;
  logic [FR_W-1:0]  base_q, base_d;
  logic             cap_en, base_en;

  logic             rv_d, rv_q;
  logic [PA_W-1:0]  pa_d, pa_q;
  pgsz_e            sz_d, sz_q;
  fault_e           flt_d, flt_q;
  logic [2:0]       fl_d, fl_q;

  logic             canon_ok;
  logic [IDX_W-1:0] cur_idx;
  logic [PA_W-1:0]  leaf_pa;
  pgsz_e            leaf_sz;

  logic             e_pres, e_wr, e_ps, e_nx, leaf_hit;
  logic [FR_W-1:0]  e_frame;

  ptw_canon #(.VA_W(VA_W)) u_canon (
    .va_hi   (req_vaddr[VA_W-1:TOP4]),
    .five_en (five_lvl_en),
    .ok      (canon_ok)
  );

  ptw_idx #(.LEVELS(MAX_LVL)) u_idx (
    .vfld (va_q[VQ_W-1:OFF_W]),
    .lvl  (lvl_q),
    .idx  (cur_idx)
  );

  ptw_leaf #(.PA_W(PA_W)) u_leaf (
    .frame (e_frame),
    .voff  (va_q[VOF_W-1:0]),
    .lvl   (lvl_q),
    .paddr (leaf_pa),
    .size  (leaf_sz)
  );

  always_comb begin
    e_frame  = mem_rsp_data[PA_W-1:OFF_W];
    e_pres   = mem_rsp_data[PRES_BIT];
    e_wr     = mem_rsp_data[WR_BIT];
    e_ps     = mem_rsp_data[PS_BIT];
    e_nx     = mem_rsp_data[NX_BIT];
    leaf_hit = (lvl_q == 3'd1) || (e_ps && (lvl_q == 3'd2 || lvl_q == 3'd3));
  end

  // next-state process
  always_comb begin
    st_d    = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    cap_en  = 1'b0;
    base_en = 1'b0;
    rv_d    = 1'b0;
    pa_d    = '0;
    sz_d    = PG_4K;
    flt_d   = FLT_NONE;
    fl_d    = 3'd0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          base_en = 1'b1;
          base_d  = root_frame;
          lvl_d   = five_lvl_en ? 3'd5 : 3'd4;
          if (!canon_ok) begin
            rv_d  = 1'b1;
            flt_d = FLT_NONCANON;
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!e_pres) begin
            rv_d = 1'b1; flt_d = FLT_NOTPRES; fl_d = lvl_q; st_d = ST_IDLE;
          end else if (acc_q == ACC_WRITE && !e_wr) begin
            rv_d = 1'b1; flt_d = FLT_WRPROT; fl_d = lvl_q; st_d = ST_IDLE;
          end else if (acc_q == ACC_FETCH && nxe_q && e_nx) begin
            rv_d = 1'b1; flt_d = FLT_NOEXEC; fl_d = lvl_q; st_d = ST_IDLE;
          end else if (leaf_hit) begin
            rv_d = 1'b1; pa_d = leaf_pa; sz_d = leaf_sz; fl_d = lvl_q;
            st_d = ST_IDLE;
          end else begin
            base_en = 1'b1;
            base_d  = e_frame;
            lvl_d   = lvl_q - 3'd1;
            st_d    = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= 3'd0;
      va_q    <= '0;
      acc_q   <= ACC_READ;
      nxe_q   <= 1'b0;
      base_q  <= '0;
      rv_q    <= 1'b0;
      pa_q    <= '0;
      sz_q    <= PG_4K;
      flt_q   <= FLT_NONE;
      fl_q    <= 3'd0;
    end else begin
      state_q <= st_d;
      rv_q    <= rv_d;
      lvl_q   <= lvl_d;
      if (cap_en) begin
        va_q  <= req_vaddr[VQ_W-1:0];
        acc_q <= acc_e'(req_access);
        nxe_q <= nx_en;
      end
      if (base_en) base_q <= base_d;
      if (rv_d) begin
        pa_q  <= pa_d;
        sz_q  <= sz_d;
        flt_q <= flt_d;
        fl_q  <= fl_d;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_ISSUE);
  assign mem_rd_addr  = {base_q, cur_idx, {ENT_SHIFT{1'b0}}};
  assign rsp_valid    = rv_q;
  assign rsp_paddr    = pa_q;
  assign rsp_size     = sz_q;
  assign rsp_fault    = flt_q;
  assign rsp_level    = fl_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
  import ptw_pkg::*;
#(
  parameter int VA_W = 64,
  localparam int TOP4 = OFF_W + 4 * IDX_W - 1,
  localparam int TOP5 = OFF_W + 5 * IDX_W - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            five_lvl_en,
  input logic            mem_rd_valid,
  input logic            mem_rsp_valid,
  input logic            rsp_valid,
  input logic [2:0]      rsp_fault,
  input logic [1:0]      rsp_size
);
  logic canon4, canon5, canon, outstanding_q;

  always_comb begin
    canon4 = (req_vaddr[VA_W-1:TOP4] == {(VA_W-TOP4){req_vaddr[TOP4]}});
    canon5 = (req_vaddr[VA_W-1:TOP5] == {(VA_W-TOP5){req_vaddr[TOP5]}});
    canon  = five_lvl_en ? canon5 : canon4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding_q <= 1'b0;
    else if (mem_rd_valid) outstanding_q <= 1'b1;
    else if (mem_rsp_valid) outstanding_q <= 1'b0;
  end

  // R1 R2
  noncanon_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !canon) |=> (rsp_valid && rsp_fault == 3'd1 && !mem_rd_valid));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !outstanding_q);

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  // R12
  rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_rsp_valid) || $past(req_valid && req_ready)));

  // R12
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  // R5
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd0) |-> (rsp_size != 2'd3));
endmodule

bind ptw_top ptw_chk #(.VA_W(VA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .five_lvl_en   (five_lvl_en),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_size      (rsp_size)
);

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
  localparam int CLK_P = 10;
  localparam logic [51:0] LEAF_FR = 52'hABC0000000;

  logic        clk, rst_n;
  logic        req_valid, five_lvl_en, nx_en, req_ready;
  logic [63:0] req_vaddr;
  logic [1:0]  req_access;
  logic [39:0] root_frame;
  logic        mem_rd_valid, mem_rsp_valid, rsp_valid;
  logic [51:0] mem_rd_addr, rsp_paddr;
  logic [63:0] mem_rsp_data;
  logic [1:0]  rsp_size;
  logic [2:0]  rsp_fault, rsp_level;

  int checks = 0, errors = 0;
  int np_lvl, ro_lvl, nx_lvl, leaf_lvl, exp_lvl, rd_cnt, addr_err, pend;
  logic [63:0] cur_va, pend_data;

  ptw_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_access(req_access), .five_lvl_en(five_lvl_en), .nx_en(nx_en),
    .root_frame(root_frame), .req_ready(req_ready), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_size(rsp_size), .rsp_fault(rsp_fault), .rsp_level(rsp_level)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  function automatic logic [51:0] tbl_base(int l);
    return 52'h10000000 + (52'(l) << 20);
  endfunction

  function automatic logic [8:0] vidx(logic [63:0] va, int l);
    return va[12 + 9 * (l - 1) +: 9];
  endfunction

  function automatic logic [63:0] mk_entry(int l);
    logic [63:0] e;
    logic [51:0] nb;
    e = '0;
    e[62:52] = 11'h5A5;
    e[0] = (l != np_lvl);
    e[1] = (l != ro_lvl);
    e[63] = (l == nx_lvl);
    if (l == leaf_lvl || l == 1) begin
      e[51:12] = LEAF_FR[51:12];
      e[7] = 1'b1;
    end else begin
      nb = tbl_base(l - 1);
      e[51:12] = nb[51:12];
      e[7] = (l >= 4);
    end
    return e;
  endfunction

  function automatic logic [63:0] mkva(int k, bit five);
    logic [63:0] raw;
    raw = 64'h9E3779B97F4A7C15 * 64'(k + 1);
    if (five) return {{7{raw[56]}}, raw[56:0]};
    return {{16{raw[47]}}, raw[47:0]};
  endfunction

  task automatic chk(input string req, input bit ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  // memory model: one response per read, latency 1..3 cycles
  initial begin
    logic [51:0] ea;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    pend = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_data;
        end
      end
      if (mem_rd_valid) begin
        ea = tbl_base(exp_lvl) | {40'd0, vidx(cur_va, exp_lvl), 3'b000};
        if (mem_rd_addr !== ea || pend != 0 || exp_lvl < 1) addr_err++;
        pend_data = mk_entry(exp_lvl);
        pend = 1 + (rd_cnt % 3);
        rd_cnt++;
        exp_lvl--;
      end
    end
  end

  task automatic walk(input logic [63:0] va, input int acc, input bit five, input bit nxe,
                      input int np, input int ro, input int nx, input int leaf,
                      input string tag, input bit poke);
    int top, l, ef, ereads, esz;
    logic [51:0] epa, rb;
    bit got, quiet;
    logic [51:0] apa;
    logic [2:0] af, al;
    logic [1:0] asz;
    np_lvl = np; ro_lvl = ro; nx_lvl = nx; leaf_lvl = leaf;
    cur_va = va;
    top = five ? 5 : 4;
    exp_lvl = top; rd_cnt = 0; addr_err = 0;
    l = top; ef = -1;
    while (ef < 0) begin
      if (l == np) ef = 2;
      else if (acc == 1 && l == ro) ef = 3;
      else if (acc == 2 && nxe && l == nx) ef = 4;
      else if (l == leaf || l == 1) ef = 0;
      else l--;
    end
    ereads = top - l + 1;
    esz = 0; epa = '0;
    if (ef == 0) begin
      esz = l - 1;
      if (l == 3) epa = {LEAF_FR[51:30], va[29:0]};
      else if (l == 2) epa = {LEAF_FR[51:21], va[20:0]};
      else epa = {LEAF_FR[51:12], va[11:0]};
    end
    rb = tbl_base(top);
    req_vaddr = va; req_access = acc[1:0]; five_lvl_en = five; nx_en = nxe;
    root_frame = rb[51:12]; req_valid = 1'b1;
    chk("R12", req_ready === 1'b1, $sformatf("ready before request actual=%b expected=1", req_ready));
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_vaddr = ~va; req_access = 2'd1; req_valid = 1'b1;
      chk("R12", req_ready === 1'b0, $sformatf("ready while busy actual=%b expected=0", req_ready));
      @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = va;
    end
    got = 1'b0; apa = '0; af = '0; al = '0; asz = '0;
    for (int c = 0; c < 60 && !got; c++) begin
      if (rsp_valid) begin
        got = 1'b1; apa = rsp_paddr; af = rsp_fault; al = rsp_level; asz = rsp_size;
      end else @(negedge clk);
    end
    chk(tag, got && af == 3'(ef) && al == 3'(l) && asz == 2'(esz) && apa == epa,
        $sformatf("got=%b fault=%0d lvl=%0d size=%0d pa=%h expected fault=%0d lvl=%0d size=%0d pa=%h",
                  got, af, al, asz, apa, ef, l, esz, epa));
    quiet = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (rsp_valid || mem_rd_valid) quiet = 1'b0;
    end
    chk("R12", quiet, $sformatf("extra activity after response actual=%b expected=1", quiet));
    chk("R3 R4", rd_cnt == ereads && addr_err == 0,
        $sformatf("reads=%0d addr_err=%0d expected reads=%0d addr_err=0", rd_cnt, addr_err, ereads));
  endtask

  task automatic noncanon(input logic [63:0] va, input bit five, input string tag);
    bit seen, quiet;
    rd_cnt = 0;
    req_vaddr = va; req_access = 2'd0; five_lvl_en = five; nx_en = 1'b0;
    root_frame = 40'h10000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = rsp_valid && rsp_fault == 3'd1 && rsp_level == 3'd0;
    chk(tag, seen, $sformatf("va=%h valid=%b fault=%0d lvl=%0d expected valid=1 fault=1 lvl=0",
                             va, rsp_valid, rsp_fault, rsp_level));
    quiet = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (rsp_valid) quiet = 1'b0;
    end
    chk(tag, quiet && rd_cnt == 0, $sformatf("reads=%0d quiet=%b expected reads=0 quiet=1", rd_cnt, quiet));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_access = '0;
    five_lvl_en = 1'b0; nx_en = 1'b0; root_frame = '0;
    np_lvl = 0; ro_lvl = 0; nx_lvl = 0; leaf_lvl = 1; exp_lvl = 0;
    rd_cnt = 0; addr_err = 0; cur_va = '0;
    repeat (3) @(negedge clk);
    chk("R13", req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_valid === 1'b0,
        $sformatf("reset ready=%b rsp=%b rd=%b expected 1 0 0", req_ready, rsp_valid, mem_rd_valid));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_valid === 1'b0,
        $sformatf("after reset ready=%b rsp=%b rd=%b expected 1 0 0", req_ready, rsp_valid, mem_rd_valid));

    // successful walks: all depths, leaf levels, access kinds
    for (int f = 0; f < 2; f++)
      for (int lf = 1; lf <= 3; lf++)
        for (int a = 0; a < 3; a++)
          for (int k = 0; k < 4; k++)
            walk(mkva(k + 4 * lf, f[0]), a, f[0], 1'b1, 0, 0, 0, lf,
                 lf == 3 ? "R5" : (lf == 2 ? "R6" : "R7"), 1'b0);

    // not-present at every level
    for (int f = 0; f < 2; f++)
      for (int l = 1; l <= 4 + f; l++)
        for (int a = 0; a < 3; a++)
          walk(mkva(l + 20, f[0]), a, f[0], 1'b1, l, 0, 0, 1, "R8", 1'b0);

    // write-protect at every level
    for (int f = 0; f < 2; f++)
      for (int l = 1; l <= 4 + f; l++)
        for (int a = 0; a < 3; a++)
          walk(mkva(l + 30, f[0]), a, f[0], 1'b0, 0, l, 0, 1, "R9", 1'b0);

    // no-execute at every level, enable on and off
    for (int f = 0; f < 2; f++)
      for (int l = 1; l <= 4 + f; l++)
        for (int a = 0; a < 3; a++)
          for (int e = 0; e < 2; e++)
            walk(mkva(l + 40, f[0]), a, f[0], e[0], 0, 0, l, 2, "R10", 1'b0);

    // ordering and precedence
    for (int f = 0; f < 2; f++)
      for (int l = 1; l <= 3; l++) begin
        walk(mkva(l + 50, f[0]), 1, f[0], 1'b1, l, l, l, 1, "R11", 1'b0);
        walk(mkva(l + 50, f[0]), 2, f[0], 1'b1, l, l, l, 1, "R11", 1'b0);
        walk(mkva(l + 60, f[0]), 1, f[0], 1'b1, l, 4, 0, 1, "R11", 1'b0);
        walk(mkva(l + 60, f[0]), 2, f[0], 1'b1, 0, l, 4, 1, "R11", 1'b0);
      end

    // request while busy is ignored
    walk(mkva(77, 1'b1), 0, 1'b1, 1'b0, 0, 0, 0, 1, "R12", 1'b1);
    walk(mkva(78, 1'b0), 2, 1'b0, 1'b1, 0, 0, 0, 3, "R12", 1'b1);

    // sign-extension boundaries
    walk(64'h00007FFFFFFFFFFF, 0, 1'b0, 1'b0, 0, 0, 0, 1, "R1", 1'b0);
    walk(64'hFFFF800000000000, 0, 1'b0, 1'b0, 0, 0, 0, 1, "R1", 1'b0);
    walk(64'h0000800000000000, 0, 1'b1, 1'b0, 0, 0, 0, 1, "R2", 1'b0);
    walk(64'hFF00000000000000, 0, 1'b1, 1'b0, 0, 0, 0, 1, "R2", 1'b0);
    walk(64'h00FFFFFFFFFFFFFF, 1, 1'b1, 1'b0, 0, 0, 0, 2, "R2", 1'b0);
    noncanon(64'h0000800000000000, 1'b0, "R1");
    noncanon(64'hFFFF7FFFFFFFFFFF, 1'b0, "R1");
    noncanon(64'h8000000000000000, 1'b0, "R1");
    noncanon(64'h0001000000000000, 1'b0, "R1");
    noncanon(64'h0100000000000000, 1'b1, "R2");
    noncanon(64'hFEFFFFFFFFFFFFFF, 1'b1, "R2");
    noncanon(64'h7FFFFFFFFFFFFFFF, 1'b1, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule